// File: doc/BRIEF.md
# Serial Control-Sequence Reset Detector

This block listens, without driving anything, to a console serial receive line that carries 8N1 characters. It watches for a short run of control characters that a remote operator types when a processor has hung. Control-X followed soon after by Control-Y produces a processor abort pulse. If Control-Z then follows within a longer window, the block also produces a backplane reset pulse. A Control-X on its own produces nothing, because the software on the console handles that key.

All timing is counted in clock cycles. A parameter sets the bit period, another the abort window, another the reset window and another the pulse width. The backplane reset can be suppressed with an enable input. Both pulse outputs are active-low.

Top module: `ctrl_seq_reset_detector`

## Requirements
- R1: The receiver takes characters framed as one low start bit, eight data bits with the least significant bit first, and one high stop bit, each bit lasting BIT_CLKS cycles. The idle line is high.
- R2: A Control-X (0x18) followed by a Control-Y (0x19) that completes fewer than WIN1_CLKS cycles after the Control-X completed produces exactly one abort pulse.
- R3: Control-X, Control-Y, Control-Z (0x1A), with the Control-Z completing fewer than WIN2_CLKS cycles after the Control-X, produces exactly one backplane reset pulse when bp_en is high.
- R4: A lone Control-X, or a Control-X followed by any character other than Control-Y, produces no pulse. Any unexpected character returns the matcher to idle.
- R5: A Control-Y that arrives after the abort window has expired produces no abort pulse. A Control-Z that arrives after the reset window has expired produces no reset pulse.
- R6: A character whose stop bit is sampled low is discarded and returns the matcher to idle.
- R7: With bp_en low, a complete Control-X, Control-Y, Control-Z sequence still produces the abort pulse but produces no backplane reset pulse.
- R8: Each pulse holds its output low for exactly PULSE_CLKS cycles.
- R9: After reset, abort_n and bp_reset_n are both high.
- R10: A Control-X received at any point restarts the sequence and its window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Monitored serial receive line, idle high |
| bp_en | input | 1 | Allows the backplane reset pulse when high |
| abort_n | output | 1 | Processor abort pulse, active low |
| bp_reset_n | output | 1 | Backplane reset pulse, active low |

## Verification
The assertions assume that rxd holds each bit for a full bit period. They also assume that bp_en does not change in the cycle a Control-Z completes. The stimulus meets both conditions. Characters are driven only by a task that holds every bit for exactly BIT_CLKS cycles and leaves two idle bits after each stop bit. bp_en changes only between sequences, while the line is idle. The random character gaps are either zero or longer than the reset window, so every expected outcome is clear of the window edges.

// File: rtl/ctrl_seq_reset_detector.sv
module ctrl_seq_reset_detector #(
  parameter int BIT_CLKS   = 1042,
  parameter int WIN1_CLKS  = 5_000_000,
  parameter int WIN2_CLKS  = 10_000_000,
  parameter int PULSE_CLKS = 100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic bp_en,
  output logic abort_n,
  output logic bp_reset_n
);
  localparam int BW = $clog2(BIT_CLKS + 1);
  localparam int CW = $clog2(WIN2_CLKS + 1);
  localparam int PW = $clog2(PULSE_CLKS + 1);
  localparam logic [7:0] K_X = 8'h18, K_Y = 8'h19, K_Z = 8'h1A;

  typedef enum logic [1:0] {S_IDLE, S_X, S_XY} seq_t;

  logic [2:0]    sync;
  logic          busy, char_vld, frame_err;
  logic [3:0]    bit_idx;
  logic [BW-1:0] bit_tmr;
  logic [7:0]    shreg;
  seq_t          st;
  logic [CW-1:0] elapsed;
  logic [PW-1:0] ab_cnt, rs_cnt;

  wire rx   = sync[1];
  wire fall = sync[2] & ~sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 3'b111;
    else        sync <= {sync[1:0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; bit_idx <= '0; bit_tmr <= '0; shreg <= '0;
      char_vld <= 1'b0; frame_err <= 1'b0;
    end else begin
      char_vld  <= 1'b0;
      frame_err <= 1'b0;
      if (!busy) begin
        if (fall) begin
          busy    <= 1'b1;
          bit_idx <= '0;
          bit_tmr <= BW'(BIT_CLKS / 2 - 1);
        end
      end else if (bit_tmr != '0) begin
        bit_tmr <= bit_tmr - 1'b1;
      end else begin
        bit_tmr <= BW'(BIT_CLKS - 1);
        bit_idx <= bit_idx + 1'b1;
        if (bit_idx == 4'd0) begin
          if (rx) busy <= 1'b0;
        end else if (bit_idx <= 4'd8) begin
          shreg <= {rx, shreg[7:1]};
        end else begin
          busy      <= 1'b0;
          char_vld  <= rx;
          frame_err <= ~rx;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; elapsed <= '0; ab_cnt <= '0; rs_cnt <= '0;
    end else begin
      if (ab_cnt != '0) ab_cnt <= ab_cnt - 1'b1;
      if (rs_cnt != '0) rs_cnt <= rs_cnt - 1'b1;
      if (st != S_IDLE) elapsed <= elapsed + 1'b1;
      if (char_vld && shreg == K_X) begin
        st <= S_X;
        elapsed <= '0;
      end else if (frame_err) begin
        st <= S_IDLE;
      end else if (st == S_X && elapsed >= CW'(WIN1_CLKS)) begin
        st <= S_IDLE;
      end else if (st == S_XY && elapsed >= CW'(WIN2_CLKS)) begin
        st <= S_IDLE;
      end else if (char_vld) begin
        st <= S_IDLE;
        if (st == S_X && shreg == K_Y) begin
          st     <= S_XY;
          ab_cnt <= PW'(PULSE_CLKS);
        end else if (st == S_XY && shreg == K_Z && bp_en) begin
          rs_cnt <= PW'(PULSE_CLKS);
        end
      end
    end
  end

  assign abort_n    = (ab_cnt == '0);
  assign bp_reset_n = (rs_cnt == '0);

  AST_ONE_OUTCOME:  assert property (@(posedge clk) disable iff (!rst_n) !(char_vld && frame_err)); // R1
  AST_ABORT_SEQ:    assert property (@(posedge clk) disable iff (!rst_n) $fell(abort_n) |-> $past(st) == S_X); // R2
  AST_RESET_SEQ:    assert property (@(posedge clk) disable iff (!rst_n) $fell(bp_reset_n) |-> $past(st) == S_XY); // R3
  AST_RESET_GATED:  assert property (@(posedge clk) disable iff (!rst_n) $fell(bp_reset_n) |-> $past(bp_en)); // R7
  AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) frame_err |=> st == S_IDLE); // R6
  AST_WIN_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) st == S_X |-> elapsed <= CW'(WIN1_CLKS)); // R5
endmodule

// File: tb/test_ctrl_seq_reset_detector.sv
module test_ctrl_seq_reset_detector;
  localparam int CLK_PERIOD = 10;
  localparam int BITC = 16, W1 = 600, W2 = 1200, PW = 20, LONG_GAP = 1300;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, bp_en = 1'b1;
  logic abort_n, bp_reset_n;
  int checks = 0, fails = 0;
  int ab_falls = 0, rs_falls = 0, ab_w = 0, rs_w = 0, ab_last = 0, rs_last = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_seq_reset_detector #(.BIT_CLKS(BITC), .WIN1_CLKS(W1), .WIN2_CLKS(W2), .PULSE_CLKS(PW))
    i_ctrl_seq_reset_detector (.clk(clk), .rst_n(rst_n), .rxd(rxd), .bp_en(bp_en),
                               .abort_n(abort_n), .bp_reset_n(bp_reset_n));

  logic ab_q = 1'b1, rs_q = 1'b1;
  always @(negedge clk) begin
    if (!abort_n) ab_w++;
    if (ab_q && !abort_n) ab_falls++;
    if (!ab_q && abort_n) begin ab_last = ab_w; ab_w = 0; end
    if (!bp_reset_n) rs_w++;
    if (rs_q && !bp_reset_n) rs_falls++;
    if (!rs_q && bp_reset_n) begin rs_last = rs_w; rs_w = 0; end
    ab_q = abort_n; rs_q = bp_reset_n;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c, input bit good, input int gap);
    repeat (gap) @(negedge clk);
    rxd = 1'b0; repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = c[i]; repeat (BITC) @(negedge clk); end
    rxd = good; repeat (BITC) @(negedge clk);
    rxd = 1'b1; repeat (2*BITC) @(negedge clk);
  endtask

  int ea = 0, er = 0;
  task automatic settle_and_check(input string req);
    repeat (LONG_GAP) @(negedge clk);
    check({req, " abort count"}, ab_falls, ea);
    check({req, " reset count"}, rs_falls, er);
  endtask

  function automatic int step(input int s, input logic [7:0] c, input bit good,
                              input bit en, inout int a, inout int r);
    if (!good) return 0;
    if (c == 8'h18) return 1;
    if (s == 1 && c == 8'h19) begin a++; return 2; end
    if (s == 2 && c == 8'h1A && en) r++;
    return 0;
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    check("R9 abort_n after reset", abort_n, 1);
    check("R9 bp_reset_n after reset", bp_reset_n, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R4 lone X and X followed by another character
    send(8'h18, 1, 0); settle_and_check("R4 lone X");
    send(8'h18, 1, 0); send(8'h41, 1, 0); send(8'h19, 1, 0); settle_and_check("R4 X other Y");
    // R1 R2 abort, R8 width
    send(8'h18, 1, 0); send(8'h19, 1, 0); ea++; settle_and_check("R2 X Y");
    check("R8 abort width", ab_last, PW);
    // R5 late Y
    send(8'h18, 1, 0); send(8'h19, 1, 700); settle_and_check("R5 late Y");
    // R3 full sequence, R8 width
    send(8'h18, 1, 0); send(8'h19, 1, 0); send(8'h1A, 1, 0); ea++; er++; settle_and_check("R3 X Y Z");
    check("R8 reset width", rs_last, PW);
    // R5 late Z
    send(8'h18, 1, 0); send(8'h19, 1, 0); send(8'h1A, 1, 1000); ea++; settle_and_check("R5 late Z");
    // R6 framing error clears the sequence
    send(8'h18, 1, 0); send(8'h19, 0, 0); send(8'h19, 1, 0); settle_and_check("R6 bad stop");
    // R7 enable low
    bp_en = 1'b0;
    send(8'h18, 1, 0); send(8'h19, 1, 0); send(8'h1A, 1, 0); ea++; settle_and_check("R7 disabled");
    bp_en = 1'b1;
    // R10 restart with a second X
    send(8'h18, 1, 0); send(8'h18, 1, 0); send(8'h19, 1, 0); ea++; settle_and_check("R10 X X Y");
    // random sequences
    for (int n = 0; n < 30; n++) begin
      int s = 0;
      int len = 1 + int'($urandom_range(4));
      bp_en = $urandom_range(1);
      for (int k = 0; k < len; k++) begin
        logic [7:0] c;
        int pick = int'($urandom_range(5));
        bit good = (pick != 5);
        bit lg = ($urandom_range(7) == 0);
        c = (pick == 0) ? 8'h41 : (pick == 1 || pick == 5) ? 8'h19 :
            (pick == 2) ? 8'h1A : 8'h18;
        if (k == 0) c = 8'h18;
        if (lg) s = 0;
        s = step(s, c, good, bp_en, ea, er);
        send(c, good, lg ? LONG_GAP : 0);
      end
      settle_and_check("R2 R3 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule